// File: doc/BRIEF.md
# Three-Buffer Event Store Busy Manager

This block manages the frame storage of a pixel sensor that holds up to three captured events. Each accepted trigger opens a capture window of programmable length. The window fills one free buffer. Stored buffers are handed to readout oldest first. The block also raises a busy flag that tells upstream logic to hold off triggers. The capture of the pixel hits themselves happens elsewhere. This block only tracks which buffers are free, filling or stored.

Two operating modes apply. In triggered mode, stored events take precedence. Busy rises when the window takes the last free buffer, a trigger that arrives while busy is dropped, and busy falls as soon as any readout completes. In continuous mode, the block keeps one buffer free at all times. Busy rises when a window takes the second buffer. A trigger that arrives while busy is still accepted: if two events are already stored, the one under readout is discarded and a one-cycle trailer flag reports the cut. Busy falls once at least two buffers are free.

Top module: `meb_busy_mgr`

## Requirements
- R1: While rst_n is low, strobe_o, busy_o, rd_valid_o and trailer_o are all 0.
- R2: A trigger accepted on a clock edge raises strobe_o from that edge for win_len_i+1 cycles. The filled buffer counts as stored from the edge on which strobe_o falls.
- R3: In both modes, trig_i is ignored while strobe_o is high. The running window is neither restarted nor extended.
- R4: In triggered mode (cont_mode_i=0), busy_o rises on the same edge as strobe_o when two buffers are already stored, which means the window takes the last free buffer.
- R5: In triggered mode, trig_i is ignored while busy_o is high.
- R6: In triggered mode, busy_o falls on the edge that samples rd_done_i high while rd_valid_o is high.
- R7: In continuous mode (cont_mode_i=1), busy_o rises on the same edge as strobe_o when at least one buffer is already stored.
- R8: In continuous mode, a trigger is accepted while busy_o is high. If two buffers are stored at that point, the oldest one is dropped: mem_sel_o advances to the next stored buffer and trailer_o is high for exactly one cycle.
- R9: In continuous mode, busy_o falls on the edge after which the number of stored buffers plus the buffer being filled is at most one.
- R10: Buffers are filled in the rotating order 0, 1, 2, 0, and so on. Stored buffers are read oldest first. mem_sel_o (a 2-bit value from 0 to 2) gives the oldest stored buffer, and rd_valid_o is high whenever at least one buffer is stored.
- R11: rd_done_i is ignored while rd_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger request |
| rd_done_i | input | 1 | Readout of the buffer given by mem_sel_o is complete |
| cont_mode_i | input | 1 | 1 selects continuous mode, 0 selects triggered mode |
| win_len_i | input | WLEN_W | Capture window length minus one, in cycles |
| strobe_o | output | 1 | Capture window open |
| mem_sel_o | output | 2 | Buffer currently presented for readout |
| rd_valid_o | output | 1 | At least one buffer is stored |
| busy_o | output | 1 | Busy indication |
| trailer_o | output | 1 | One-cycle pulse: a readout was cut short |

## Verification
The bench builds the block with WLEN_W=4. This brings both window-length extremes within reach: one cycle (win_len_i=0) and sixteen cycles (win_len_i=15). A cycle model written from the requirements predicts every output, and a scoreboard compares the prediction with the design each cycle. The stimulus drives both modes through every buffer occupancy. It covers triggers that land inside a window or during busy, back-to-back continuous triggers that force repeated drops across the ring wrap, and readout completions that arrive with nothing stored or on the same edge as a window closing.

// File: rtl/meb_busy_mgr.sv
module meb_busy_mgr #(
  parameter int WLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              rd_done_i,
  input  logic              cont_mode_i,
  input  logic [WLEN_W-1:0] win_len_i,
  output logic              strobe_o,
  output logic [1:0]        mem_sel_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              trailer_o
);

  localparam logic [1:0] LAST_IDX = 2'd2;

  logic [1:0]        rd_ptr, full_cnt;
  logic [WLEN_W-1:0] cnt;
  logic              strobe, busy, trailer;

  function automatic logic [1:0] inc3(input logic [1:0] v);
    return (v == LAST_IDX) ? 2'd0 : v + 2'd1;
  endfunction

  logic       done_eff, accept, abort, win_end, busy_nx;
  logic [1:0] full_ad, full_aa, full_nx, rd_nx;
  logic [2:0] occ_nx;

  assign done_eff = rd_done_i && (full_cnt != 2'd0);
  assign full_ad  = full_cnt - {1'b0, done_eff};
  assign accept   = trig_i && !strobe && (cont_mode_i || !busy);
  assign abort    = cont_mode_i && accept && (full_ad >= 2'd2);
  assign win_end  = strobe && (cnt == '0);
  assign full_aa  = full_ad - {1'b0, abort};
  assign full_nx  = full_aa + {1'b0, win_end};
  assign occ_nx   = {1'b0, full_ad} + {2'b0, strobe};

  always_comb begin
    case ({done_eff, abort})
      2'b00:   rd_nx = rd_ptr;
      2'b11:   rd_nx = inc3(inc3(rd_ptr));
      default: rd_nx = inc3(rd_ptr);
    endcase
  end

  always_comb begin
    if (cont_mode_i)
      busy_nx = accept ? (full_aa != 2'd0) : (busy && (occ_nx >= 3'd2));
    else
      busy_nx = accept ? (full_ad == 2'd2) : (busy && !done_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= 2'd0;
      full_cnt <= 2'd0;
      cnt      <= '0;
      strobe   <= 1'b0;
      busy     <= 1'b0;
      trailer  <= 1'b0;
    end else begin
      rd_ptr   <= rd_nx;
      full_cnt <= full_nx;
      busy     <= busy_nx;
      trailer  <= abort;
      if (accept) begin
        strobe <= 1'b1;
        cnt    <= win_len_i;
      end else if (win_end) begin
        strobe <= 1'b0;
      end else if (strobe) begin
        cnt    <= cnt - 1'b1;
      end
    end
  end

  assign strobe_o   = strobe;
  assign mem_sel_o  = rd_ptr;
  assign rd_valid_o = (full_cnt != 2'd0);
  assign busy_o     = busy;
  assign trailer_o  = trailer;

endmodule

module meb_busy_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_i,
  input logic       rd_done_i,
  input logic       cont_mode_i,
  input logic       strobe_o,
  input logic [1:0] mem_sel_o,
  input logic       rd_valid_o,
  input logic       busy_o,
  input logic       trailer_o
);

  p_strobe_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $past(trig_i));

  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_mode_i && busy_o && !strobe_o) |=> !strobe_o);

  p_busy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_mode_i && busy_o && rd_done_i && rd_valid_o) |=> !busy_o);

  p_trailer_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trailer_o |-> $past(cont_mode_i && trig_i));

  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_done_i && !(cont_mode_i && trig_i)) |=> $stable(mem_sel_o));

  p_empty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid_o && !strobe_o) |=> !rd_valid_o);

endmodule

bind meb_busy_mgr meb_busy_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .rd_done_i(rd_done_i),
  .cont_mode_i(cont_mode_i), .strobe_o(strobe_o), .mem_sel_o(mem_sel_o),
  .rd_valid_o(rd_valid_o), .busy_o(busy_o), .trailer_o(trailer_o)
);

// File: tb/meb_busy_mgr_test.sv
module meb_busy_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam int WLW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, done = 1'b0, cont = 1'b0;
  logic [WLW-1:0] wl = '0;
  logic strobe, valid, busy, trailer;
  logic [1:0] sel;

  int vectors = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  meb_busy_mgr #(.WLEN_W(WLW)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .rd_done_i(done),
    .cont_mode_i(cont), .win_len_i(wl), .strobe_o(strobe),
    .mem_sel_o(sel), .rd_valid_o(valid), .busy_o(busy), .trailer_o(trailer)
  );

  typedef struct {bit s; bit b; bit v; bit [1:0] m; bit t;} exp_t;
  exp_t expq[$];

  int  fifo[$];
  bit  m_strobe, m_busy;
  int  m_cnt, m_wr, m_tgt;

  task automatic miscompare(string tag, int act, int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      vectors++;
      if (strobe !== e.s)  miscompare("R2/R3 strobe", strobe, e.s);
      if (busy !== e.b)    miscompare("R4/R5/R6/R7/R9 busy", busy, e.b);
      if (valid !== e.v)   miscompare("R10/R11 rd_valid", valid, e.v);
      if (e.v && sel !== e.m) miscompare("R10 mem_sel", sel, e.m);
      if (trailer !== e.t) miscompare("R8 trailer", trailer, e.t);
    end
  end

  task automatic step(bit t, bit d);
    bit done_eff, win_end, accept, trl;
    exp_t e;
    @(negedge clk); #1;
    trig = t; done = d;
    done_eff = d && fifo.size() > 0;
    if (done_eff) void'(fifo.pop_front());
    win_end = m_strobe && m_cnt == 0;
    accept  = t && !m_strobe && (cont || !m_busy);
    trl = 0;
    if (accept && cont && fifo.size() >= 2) begin
      void'(fifo.pop_front());
      trl = 1;
    end
    if (accept) m_busy = cont ? (fifo.size() >= 1) : (fifo.size() == 2);
    else if (cont) m_busy = m_busy && (fifo.size() + int'(m_strobe)) >= 2;
    else m_busy = m_busy && !done_eff;
    if (win_end) begin
      fifo.push_back(m_tgt);
      m_strobe = 0;
    end else if (m_strobe) m_cnt--;
    if (accept) begin
      m_tgt = m_wr; m_wr = (m_wr + 1) % 3;
      m_strobe = 1; m_cnt = int'(wl);
    end
    e.s = m_strobe; e.b = m_busy; e.v = fifo.size() > 0;
    e.m = fifo.size() > 0 ? 2'(fifo[0]) : 2'd0; e.t = trl;
    expq.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic do_reset(bit mode, int len);
    @(negedge clk); #1;
    rst_n = 0; trig = 0; done = 0; cont = mode; wl = WLW'(len);
    fifo.delete(); m_strobe = 0; m_busy = 0; m_cnt = 0; m_wr = 0; m_tgt = 0;
    @(negedge clk);
    vectors++;
    if ({strobe, busy, valid, trailer} !== 4'b0)
      miscompare("R1 reset outputs", {strobe, busy, valid, trailer}, 0);
    #1 rst_n = 1;
  endtask

  initial begin
    // R1 R2 R10: triggered mode, window length 3
    do_reset(0, 2);
    step(1, 0); idle(4);
    // R3: triggers inside an open window
    step(1, 0); step(1, 0); step(1, 0); idle(3);
    // R4: third window takes the last free buffer
    step(1, 0); idle(4);
    // R5: trigger while busy
    step(1, 0); idle(2);
    // R6: readout done clears busy
    step(0, 1); idle(1);
    step(1, 0); idle(4);
    for (int i = 0; i < 3; i++) begin step(0, 1); idle(1); end
    // R11: done with nothing stored
    step(0, 1); step(0, 1); idle(1);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1); idle(2);

    // R7 R8 R9: continuous mode, window length 2
    do_reset(1, 1);
    for (int i = 0; i < 6; i++) begin step(1, 0); idle(3); end
    step(1, 0); step(1, 0); idle(3);
    step(0, 1); idle(1); step(0, 1); idle(2);
    step(1, 0); step(0, 0); step(0, 1); step(1, 0); step(0, 1); idle(3);
    step(1, 1); idle(3); step(1, 1); idle(3);

    // R2: window length extremes
    do_reset(1, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 1); step(1, 1); idle(2);
    do_reset(0, 15);
    step(1, 0); idle(8); step(1, 0); idle(10); step(0, 1); idle(2);

    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule